// File: doc/BRIEF.md
# Ratiometric ADC Conversion Sequencer

This block controls a converter through two 32-bit word registers: a control/status word and a read-only result word. Software writes the control word to pick an input channel and a reference, to set a clock divider and to start a conversion. The block then counts the conversion window in prescaled periods. Near the end of the window it captures the selected channel word and the reference, and forms the 10-bit ratio with a small sequential divider. When the window closes it stores the result and clears the busy bit. If interrupts are enabled, it also raises a level interrupt.

The analog front end is modelled by digital channel words, one per input, and by an external reference word. A fixed internal reference can be selected in its place. A self-clearing reset bit in the control word returns the whole block to its power-up state.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x000C0001, the result word reads 0 and irq_o is low.
- R2: Only requests with size_i = 2 (word) and addr_i[1:0] = 0 act. Offset 0x0 selects the control word and offset 0x4 the result word. Any other access reads 0 and writes nothing, and writes to offset 0x4 are ignored.
- R3: Control fields: mux select [27:24], interrupt enable [21], reference select [19], interrupt flag [18], enable [17], soft reset [16], convert/busy [13], divider [8:1]. Every other bit is stored and read back exactly as written.
- R4: Writing 1 to bit 18 clears the flag and drops irq_o. Writing 0 to it leaves the flag as it was.
- R5: A control write with bit 16 set applies the full reset state of R1, discards the rest of the written value and abandons any running conversion.
- R6: With enable set in the written value, a write that moves bit 13 from 0 to 1 starts a conversion, and restarts one already running. A write that keeps bit 13 at 1 starts nothing.
- R7: With enable set in the written value, a write with bit 13 at 0 cancels a running conversion, and no completion follows.
- R8: With enable clear in the written value, bit 13 is stored as written, nothing starts, and a running conversion continues to completion.
- R9: A conversion completes exactly 40*(DIV+1) clock cycles after the start write. DIV is the divider field of the start write, and later writes do not change the timing.
- R10: The result is min(1023, floor(word*1024/ref)). ref is 2,000,000 when bit 19 is 1 and ext_ref_i otherwise, and a ref of 0 gives 1023. The channel word, the mux field and the reference are captured 12 cycles before completion.
- R11: At completion the result word takes the result and bit 13 clears. If bit 21 is set, the flag sets and irq_o rises.
- R12: If the captured mux value is 8 or more, completion leaves the result word, the flag, irq_o and bit 13 unchanged.
- R13: irq_o is never high while the flag bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address within the block |
| size_i | input | 2 | Access size code, 2 = 32-bit word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 unless an accepted read |
| chan_i | input | NCH*IN_W | Packed channel words, channel k at [k*IN_W +: IN_W] |
| ext_ref_i | input | IN_W | External reference word |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest states to reach are those in which the busy bit no longer matches the timer. One is a conversion left running after a write with enable clear and convert at 0. A later enabled convert write then has to restart the window rather than be ignored. The other is a completion on an invalid mux value, which leaves busy set with no timer behind it. The stimulus reaches both by sequencing control writes in the middle of a window. It also changes channel words both before and after the capture point. A behavioural model of the window and capture counts predicts every read and every irq_o level cycle by cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int MUX_LO    = 24;
  localparam int MUX_W     = 4;
  localparam int B_IE      = 21;
  localparam int B_REFSEL  = 19;
  localparam int B_FLAG    = 18;
  localparam int B_EN      = 17;
  localparam int B_SRST    = 16;
  localparam int B_CONV    = 13;
  localparam int DIV_LO    = 1;
  localparam int DIV_W     = 8;
  localparam int RES_W     = 10;
  localparam logic [31:0] CTRL_RST = 32'h000C_0001;
  localparam logic [1:0]  SZ_WORD  = 2'b10;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int PERIODS = 20,
  parameter int DIV_W   = 8,
  parameter int LEAD    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sample_o,
  output logic             done_o,
  output logic             active_o
);
  localparam int MAX_T = 2 * PERIODS * (1 << DIV_W);
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] rem_q;
  logic             act_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'((32'(div_i) + 32'd1) * 32'(2 * PERIODS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else if (stop_i) begin
      act_q <= 1'b0;
    end else if (start_i) begin
      act_q <= 1'b1;
      rem_q <= load_val;
    end else if (act_q) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == CNT_W'(1)) act_q <= 1'b0;
    end
  end

  assign sample_o = act_q && (rem_q == CNT_W'(LEAD)) && !start_i && !stop_i;
  assign done_o   = act_q && (rem_q == CNT_W'(1)) && !start_i && !stop_i;
  assign active_o = act_q;

  assert_count_live_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (rem_q != '0));
  assert_start_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (act_q && rem_q >= CNT_W'(2 * PERIODS)));
endmodule

// File: rtl/adc_ratio_div.sv
module adc_ratio_div #(
  parameter int W  = 32,
  parameter int QW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  num_i,
  input  logic [W-1:0]  den_i,
  output logic [QW-1:0] quo_o
);
  localparam int CW = $clog2(QW + 1);

  logic [W-1:0]  rem_q, den_q;
  logic [QW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic          sat_q;
  logic [W:0]    shifted, diff;
  logic          take;

  assign shifted = {rem_q, 1'b0};
  assign diff    = shifted - {1'b0, den_q};
  assign take    = shifted >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (load_i) begin
      // num >= den means the ratio is at least 2^QW: saturate
      sat_q <= (num_i >= den_i);
      rem_q <= num_i;
      den_q <= den_i;
      quo_q <= '0;
      cnt_q <= CW'(QW);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      quo_q <= {quo_q[QW-2:0], take};
      rem_q <= take ? diff[W-1:0] : shifted[W-1:0];
    end
  end

  assign quo_o = sat_q ? {QW{1'b1}} : quo_q;

  assert_rem_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !sat_q) |-> (rem_q < den_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int          NCH          = 8,
  parameter int          IN_W         = 32,
  parameter int          ADDR_W       = 12,
  parameter int          CONV_PERIODS = 20,
  parameter int unsigned INT_REF      = 2000000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          size_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NCH*IN_W-1:0] chan_i,
  input  logic [IN_W-1:0]     ext_ref_i,
  output logic                irq_o
);
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int LEAD  = RES_W + 2;
  localparam int IDX_W = ADDR_W - 2;

  logic [31:0] ctrl_q, data_q;
  logic        irq_q, ok_q;

  logic [IN_W-1:0] chan_arr [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign chan_arr[g] = chan_i[g*IN_W +: IN_W];
  end

  // bus decode
  logic acc, wr_ctrl, rd_ok;
  logic [IDX_W-1:0] idx;
  assign idx     = addr_i[ADDR_W-1:2];
  assign acc     = req_i && (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00);
  assign wr_ctrl = acc && we_i && (idx == '0);
  assign rd_ok   = acc && !we_i;

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      if (idx == IDX_W'(0))      rdata_o = ctrl_q;
      else if (idx == IDX_W'(1)) rdata_o = data_q;
    end
  end

  // write effect on the control word
  logic [31:0] ctrl_wr, ctrl_base;
  logic        sreset, start, cancel, flag_clr;
  always_comb begin
    ctrl_wr         = wdata_i;
    ctrl_wr[B_FLAG] = wdata_i[B_FLAG] ? 1'b0 : ctrl_q[B_FLAG];
  end
  assign sreset   = wr_ctrl && wdata_i[B_SRST];
  assign flag_clr = wr_ctrl && wdata_i[B_FLAG];
  assign start    = wr_ctrl && !sreset && ctrl_wr[B_EN] && ctrl_wr[B_CONV] && !ctrl_q[B_CONV];
  assign cancel   = wr_ctrl && !sreset && ctrl_wr[B_EN] && !ctrl_wr[B_CONV];
  assign ctrl_base = wr_ctrl ? ctrl_wr : ctrl_q;

  // conversion window
  logic smp, done, tmr_act;
  adc_conv_timer #(
    .PERIODS(CONV_PERIODS),
    .DIV_W  (DIV_W),
    .LEAD   (LEAD)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .stop_i  (sreset || cancel),
    .div_i   (ctrl_wr[DIV_LO +: DIV_W]),
    .sample_o(smp),
    .done_o  (done),
    .active_o(tmr_act)
  );

  // capture and ratio
  logic [MUX_W-1:0] mux;
  logic             mux_ok;
  logic [IN_W-1:0]  num_sel, ref_sel;
  logic [RES_W-1:0] quo;
  assign mux     = ctrl_q[MUX_LO +: MUX_W];
  assign mux_ok  = 32'(mux) < NCH;
  assign num_sel = mux_ok ? chan_arr[mux[SEL_W-1:0]] : '0;
  assign ref_sel = ctrl_q[B_REFSEL] ? IN_W'(INT_REF) : ext_ref_i;

  adc_ratio_div #(
    .W (IN_W),
    .QW(RES_W)
  ) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(smp),
    .num_i (num_sel),
    .den_i (ref_sel),
    .quo_o (quo)
  );

  logic fire;
  assign fire = done && ok_q;

  logic [31:0] ctrl_d;
  always_comb begin
    ctrl_d = ctrl_base;
    if (sreset) begin
      ctrl_d = CTRL_RST;
    end else if (fire) begin
      ctrl_d[B_CONV] = 1'b0;
      if (ctrl_base[B_IE]) ctrl_d[B_FLAG] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      data_q <= '0;
      irq_q  <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (smp) ok_q <= mux_ok;
      if (sreset)    data_q <= '0;
      else if (fire) data_q <= 32'(quo);
      if (sreset)                         irq_q <= 1'b0;
      else if (fire && ctrl_base[B_IE])   irq_q <= 1'b1;
      else if (flag_clr)                  irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  assert_irq_flag_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_q[B_FLAG]);
  assert_srst_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreset |=> (ctrl_q == CTRL_RST && !irq_o && !tmr_act));
  assert_fire_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !ctrl_q[B_CONV]);
  assert_data_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_q != $past(data_q)) |-> $past(fire || sreset));
  assert_bad_mux_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !ok_q && !wr_ctrl) |=> ($stable(data_q) && ctrl_q[B_CONV] == $past(ctrl_q[B_CONV])));
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  size = 2'b10;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] chw [8];
  logic [255:0] chan_bus;
  logic [31:0] ext_ref = 32'd1000;
  logic        irq;

  int checks = 0, fails = 0;
  string phase = "R1";
  bit tgl = 1'b0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) chan_bus[i*32 +: 32] = chw[i];
  end

  adc_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .chan_i(chan_bus),
    .ext_ref_i(ext_ref), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_ctrl, m_data, m_in, m_ref;
  bit          m_irq, m_act, m_ok;
  int          m_rem;

  function automatic logic [31:0] ratio(longint unsigned a, longint unsigned b);
    longint unsigned q;
    if (b == 0) return 32'd1023;
    q = (a * 1024) / b;
    if (q > 1023) q = 1023;
    return 32'(q);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit acc, wc, srst, st, sp, clr, dn, sm;
    logic [31:0] nb;
    int mx;
    if (!rst_n) begin
      m_ctrl = 32'h000C_0001; m_data = 0; m_irq = 0; m_act = 0; m_rem = 0; m_ok = 0;
      m_in = 0; m_ref = 0;
    end else begin
      acc = req && size == 2'b10 && addr[1:0] == 2'b00;
      wc  = acc && we && addr[11:2] == 0;
      nb = m_ctrl; srst = 0; st = 0; sp = 0; clr = 0;
      dn = m_act && m_rem == 1;
      sm = m_act && m_rem == 12;
      if (wc) begin
        nb = wdata;
        nb[18] = wdata[18] ? 1'b0 : m_ctrl[18];
        clr = wdata[18];
        if (wdata[16]) srst = 1;
        else if (nb[17]) begin
          if (nb[13] && !m_ctrl[13]) st = 1;
          if (!nb[13]) sp = 1;
        end
      end
      if (srst) begin
        m_ctrl = 32'h000C_0001; m_data = 0; m_irq = 0; m_act = 0;
      end else begin
        if (sm && !st && !sp) begin
          mx = int'(m_ctrl[27:24]);
          m_ok = mx < 8;
          m_in = m_ok ? chw[mx] : 0;
          m_ref = m_ctrl[19] ? 32'd2000000 : ext_ref;
        end
        if (clr) m_irq = 0;
        if (sp) m_act = 0;
        else if (st) begin m_act = 1; m_rem = 40 * (int'(nb[8:1]) + 1); end
        else if (m_act) begin
          m_rem--;
          if (m_rem == 0) m_act = 0;
        end
        if (dn && !st && !sp && m_ok) begin
          m_data = ratio(m_in, m_ref);
          nb[13] = 0;
          if (nb[21]) begin nb[18] = 1; m_irq = 1; end
        end
        m_ctrl = nb;
      end
    end
  end

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    logic [31:0] exp_rd;
    #2;
    if (rst_n) begin
      exp_rd = 0;
      if (req && !we && size == 2'b10 && addr[1:0] == 2'b00) begin
        if (addr[11:2] == 0) exp_rd = m_ctrl;
        else if (addr[11:2] == 1) exp_rd = m_data;
      end
      checks++;
      if (rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s rdata addr=%h act=%h exp=%h", phase, addr, rdata, exp_rd);
      end
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL %s irq act=%b exp=%b", phase, irq, m_irq);
      end
    end
  end

  task automatic raw(input bit w, input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; size = s; wdata = d;
  endtask

  task automatic wr(input logic [31:0] d);
    raw(1'b1, 12'h000, 2'b10, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b1; we = 1'b0; size = 2'b10; wdata = '0;
      addr = tgl ? 12'h004 : 12'h000;
      tgl = ~tgl;
    end
  endtask

  initial begin : watchdog
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) chw[i] = 32'd1000 * (i + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1";  idle(4);
    phase = "R4";  wr(32'h0004_0000); idle(3);
    phase = "R3";  wr(32'h5A44_4A5E); idle(4); wr(32'h0000_0000); idle(2);
    phase = "R2";
    raw(1'b1, 12'h000, 2'b01, 32'h0002_2000); idle(2);
    raw(1'b1, 12'h002, 2'b10, 32'h0002_2000); idle(2);
    raw(1'b1, 12'h004, 2'b10, 32'hDEAD_BEEF); idle(2);
    raw(1'b0, 12'h008, 2'b10, 32'h0); raw(1'b0, 12'h000, 2'b01, 32'h0);
    raw(1'b0, 12'h006, 2'b10, 32'h0); idle(2);
    // internal reference, irq enabled, DIV=0
    phase = "R11"; chw[3] = 32'd1000000; wr(32'h032A_2000); idle(50);
    phase = "R13"; wr(32'h0022_0000); idle(3); wr(32'h0026_0000); idle(3);
    // external reference, DIV=3, saturation
    phase = "R10"; chw[5] = 32'd900; ext_ref = 32'd800; wr(32'h0502_2006); idle(170);
    chw[5] = 32'd333; ext_ref = 32'd1000; wr(32'h0502_0006); wr(32'h0502_2006); idle(170);
    ext_ref = 32'd0; wr(32'h0502_0006); wr(32'h0502_2006); idle(170);
    // capture point: change before and after it
    ext_ref = 32'd4096; chw[5] = 32'd7;
    wr(32'h0502_0000); wr(32'h0502_2000); idle(10); chw[5] = 32'd1234; idle(25); chw[5] = 32'd99; idle(10);
    // divider change mid-window does not retime
    phase = "R9"; wr(32'h0502_0000); wr(32'h0502_2000); idle(10); wr(32'h0502_200A); idle(45);
    // cancel
    phase = "R7"; wr(32'h032A_0000); wr(32'h032A_2000); idle(15); wr(32'h032A_0000); idle(60);
    wr(32'h0026_0000); idle(2);
    // enable clear
    phase = "R8"; wr(32'h0308_2000); idle(50);
    phase = "R6"; wr(32'h030A_2000); idle(50);
    wr(32'h030A_0000); wr(32'h030A_2000); idle(10);
    phase = "R8"; wr(32'h0308_0000); idle(45);
    phase = "R6"; chw[3] = 32'd500000;
    wr(32'h030A_0000); wr(32'h030A_2000); idle(10); wr(32'h0308_0000); idle(5);
    wr(32'h030A_2000); idle(50);
    // invalid mux
    phase = "R12"; wr(32'h092E_0000); wr(32'h092A_2000); idle(50); wr(32'h092A_0000); idle(4);
    // soft reset mid-conversion
    phase = "R5"; wr(32'h032A_0000); wr(32'h032A_2000); idle(10); wr(32'hFFFF_FFFF); idle(60);
    req = 1'b0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule